// File: doc/BRIEF.md
# Successive-Approximation Converter Serial Sequencer

This block holds the digital control and serial port of a 12-bit successive-approximation converter. It is a slave on a three-wire, half-duplex bus with an active-low chip select (`cs_n`), a serial clock (`sclk`) and one data output. Every low period of chip select frames exactly one conversion cycle. The cycle opens with a sampling window, continues with a conversion that resolves one bit per serial clock, and ends with a data phase. In the data phase the word is sent again in the opposite bit order, and then zeros follow for as long as clocking continues. A separate output enables the data-out driver, and another output tells the analog core when it may power down.

The block runs on a fast system clock, `clk`. The bus inputs must be synchronous to `clk`, and each `sclk` level must last at least two `clk` periods. Only falling edges of `sclk` advance the sequence, so `dout` changes only after a falling edge and a master can sample it on the rising edge.

The comparator is modelled inside the block so that the block can be tested on its own. The "analog" input is a digital word, `ain`, held at the end of the sampling window. Each trial code is compared against that held word. The analog front end is outside the block.

Top module: `sar_adc_serial`

## Requirements
- R1: For as long as reset is held, and one `clk` cycle after it ends while `cs_n` is high, `dout_oe` is 0 and `pwr_dn` is 1.
- R2: The `clk` cycle after `cs_n` falls, `pwr_dn` is 0. `dout_oe` stays 0 through the first two falling `sclk` edges of the cycle, which form the sampling window.
- R3: On the third falling `sclk` edge, `dout_oe` becomes 1 and `dout` shows a null bit of value 0.
- R4: Falling edges 4 through 15 present the result word on `dout` most significant bit first: bit 11 on edge 4, down to bit 0 on edge 15.
- R5: Each trial bit is kept when the trial code is not greater than the held input. The word sent therefore equals `ain` as sampled on the third falling edge, whatever `ain` does afterwards.
- R6: Falling edges 16 through 26 present the word again least significant bit first, from bit 1 up to bit 11. Bit 0 is not repeated.
- R7: From falling edge 27 on, for as long as `cs_n` stays low, `dout` is 0 and `dout_oe` stays 1, with no limit.
- R8: `pwr_dn` is 0 from the start of the cycle through edge 15, and 1 from edge 16 on.
- R9: When `cs_n` is high at a `clk` edge, the next cycle shows `dout_oe` at 0 and `pwr_dn` at 1. This holds at any point of a cycle. The next falling edge of `cs_n` starts a completely new cycle.
- R10: While `cs_n` stays low, `dout` and `dout_oe` change only after a falling edge of `sclk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select; one low period is one cycle |
| sclk | input | 1 | Serial clock from the master, synchronous to `clk` |
| ain | input | WORD_W (12) | Digital stand-in for the analog input |
| dout | output | 1 | Serial data, valid when `dout_oe` is 1 |
| dout_oe | output | 1 | Output enable for the tri-state data driver |
| pwr_dn | output | 1 | High when the comparator and bias may be powered down |

## Verification
A falling `sclk` edge is seen at the first `clk` edge that samples `sclk` low after it was high. The outputs take their new values from that same `clk` edge on, so each result is due one `clk` cycle after the falling edge. A change on `cs_n` also shows on the outputs one `clk` cycle later. The bench drives each `sclk` level for two `clk` periods and samples on the falling edge of `clk`, so every output it reads has settled. Before each falling edge, the bench also reads the outputs while `sclk` is high and compares them with their values after the previous falling edge, to confirm that nothing moved on the rising edge.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    localparam int unsigned WORD_W_DEF      = 12;
    localparam int unsigned SAMPLE_CLKS_DEF = 2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SAMPLE,
        PH_NULL,
        PH_MSB,
        PH_LSB,
        PH_ZERO
    } phase_e;

    typedef struct packed {
        logic start;
        logic abort;
        logic fall;
    } bus_evt_t;

    function automatic int unsigned cnt_width(int unsigned w, int unsigned s);
        return $clog2(((w > s) ? w : s) + 1);
    endfunction

    function automatic logic phase_drives(phase_e p);
        return (p == PH_NULL) || (p == PH_MSB) || (p == PH_LSB) || (p == PH_ZERO);
    endfunction

    function automatic logic phase_core_off(phase_e p);
        return (p == PH_IDLE) || (p == PH_LSB) || (p == PH_ZERO);
    endfunction

endpackage

// File: rtl/sar_bus_events.sv
module sar_bus_events
    import sar_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cs_n,
    input  logic     sclk,
    output bus_evt_t evt
);

    logic cs_q;
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            cs_q   <= cs_n;
            sclk_q <= sclk;
        end
    end

    always_comb begin
        evt.start = cs_q & ~cs_n;
        evt.abort = cs_n;
        evt.fall  = sclk_q & ~sclk & ~cs_n;
    end

endmodule

// File: rtl/sar_phase_ctrl.sv
module sar_phase_ctrl
    import sar_seq_pkg::*;
#(
    parameter int unsigned WORD_W      = WORD_W_DEF,
    parameter int unsigned SAMPLE_CLKS = SAMPLE_CLKS_DEF,
    localparam int unsigned CNT_W      = cnt_width(WORD_W, SAMPLE_CLKS),
    localparam int unsigned IDX_W      = $clog2(WORD_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_evt_t         evt,
    output phase_e           phase,
    output logic [CNT_W-1:0] cnt,
    output logic             load,
    output logic             decide,
    output logic [IDX_W-1:0] dec_idx
);

    localparam logic [CNT_W-1:0] SAMP_LAST = CNT_W'(SAMPLE_CLKS);
    localparam logic [CNT_W-1:0] TOP_BIT   = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

    logic [CNT_W-1:0] cnt_dn;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (evt.abort) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (evt.start) begin
            phase <= PH_SAMPLE;
            cnt   <= '0;
        end else if (evt.fall) begin
            case (phase)
                PH_SAMPLE: begin
                    if (cnt == SAMP_LAST) begin
                        phase <= PH_NULL;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + ONE;
                    end
                end
                PH_NULL: begin
                    phase <= PH_MSB;
                    cnt   <= TOP_BIT;
                end
                PH_MSB: begin
                    if (cnt == '0) begin
                        phase <= PH_LSB;
                        cnt   <= ONE;
                    end else begin
                        cnt <= cnt_dn;
                    end
                end
                PH_LSB: begin
                    if (cnt == TOP_BIT) begin
                        phase <= PH_ZERO;
                    end else begin
                        cnt <= cnt + ONE;
                    end
                end
                default: begin
                    phase <= phase;
                end
            endcase
        end
    end

    always_comb begin
        cnt_dn  = cnt - ONE;
        load    = evt.fall && (phase == PH_SAMPLE) && (cnt == SAMP_LAST);
        decide  = evt.fall && ((phase == PH_NULL) || ((phase == PH_MSB) && (cnt != '0)));
        dec_idx = (phase == PH_NULL) ? IDX_W'(WORD_W - 1) : cnt_dn[IDX_W-1:0];
    end

endmodule

// File: rtl/sar_search.sv
module sar_search
    import sar_seq_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_W_DEF,
    localparam int unsigned IDX_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] ain,
    input  logic              decide,
    input  logic [IDX_W-1:0]  dec_idx,
    output logic [WORD_W-1:0] result
);

    logic [WORD_W-1:0] held;
    logic [WORD_W-1:0] trial;
    logic              keep;

    always_comb begin
        trial = result | ({{(WORD_W-1){1'b0}}, 1'b1} << dec_idx);
        keep  = (trial <= held);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held   <= '0;
            result <= '0;
        end else if (load) begin
            held   <= ain;
            result <= '0;
        end else if (decide) begin
            result[dec_idx] <= keep;
        end
    end

endmodule

// File: rtl/sar_serial_out.sv
module sar_serial_out
    import sar_seq_pkg::*;
#(
    parameter int unsigned WORD_W      = WORD_W_DEF,
    parameter int unsigned SAMPLE_CLKS = SAMPLE_CLKS_DEF,
    localparam int unsigned CNT_W      = cnt_width(WORD_W, SAMPLE_CLKS),
    localparam int unsigned IDX_W      = $clog2(WORD_W)
) (
    input  phase_e            phase,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [WORD_W-1:0] result,
    output logic              dout,
    output logic              dout_oe,
    output logic              pwr_dn
);

    logic [IDX_W-1:0] sel;

    always_comb begin
        sel     = cnt[IDX_W-1:0];
        dout_oe = phase_drives(phase);
        pwr_dn  = phase_core_off(phase);
        if ((phase == PH_MSB) || (phase == PH_LSB)) begin
            dout = result[sel];
        end else begin
            dout = 1'b0;
        end
    end

endmodule

// File: rtl/sar_adc_serial.sv
module sar_adc_serial
    import sar_seq_pkg::*;
#(
    parameter int unsigned WORD_W      = WORD_W_DEF,
    parameter int unsigned SAMPLE_CLKS = SAMPLE_CLKS_DEF,
    localparam int unsigned CNT_W      = cnt_width(WORD_W, SAMPLE_CLKS),
    localparam int unsigned IDX_W      = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [WORD_W-1:0] ain,
    output logic              dout,
    output logic              dout_oe,
    output logic              pwr_dn
);

    bus_evt_t          evt;
    phase_e            phase;
    logic [CNT_W-1:0]  cnt;
    logic              load;
    logic              decide;
    logic [IDX_W-1:0]  dec_idx;
    logic [WORD_W-1:0] result;

    sar_bus_events u_events (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .sclk (sclk),
        .evt  (evt)
    );

    sar_phase_ctrl #(
        .WORD_W      (WORD_W),
        .SAMPLE_CLKS (SAMPLE_CLKS)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .phase   (phase),
        .cnt     (cnt),
        .load    (load),
        .decide  (decide),
        .dec_idx (dec_idx)
    );

    sar_search #(
        .WORD_W (WORD_W)
    ) u_search (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .ain     (ain),
        .decide  (decide),
        .dec_idx (dec_idx),
        .result  (result)
    );

    sar_serial_out #(
        .WORD_W      (WORD_W),
        .SAMPLE_CLKS (SAMPLE_CLKS)
    ) u_out (
        .phase   (phase),
        .cnt     (cnt),
        .result  (result),
        .dout    (dout),
        .dout_oe (dout_oe),
        .pwr_dn  (pwr_dn)
    );

endmodule

// File: rtl/sar_adc_serial_chk.sv
module sar_adc_serial_chk (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic sclk,
    input logic dout,
    input logic dout_oe,
    input logic pwr_dn
);

    // R9
    cs_high_idles_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (!dout_oe && pwr_dn));

    // R2
    start_powers_up_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |=> (!pwr_dn && !dout_oe));

    // R3
    null_bit_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dout_oe) |-> (!dout && !pwr_dn));

    // R10
    stable_between_falls_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !($past(sclk) && !sclk)) |=> ($stable(dout) && $stable(dout_oe)));

    // R7
    driver_held_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && dout_oe) |=> dout_oe);

endmodule

bind sar_adc_serial sar_adc_serial_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (cs_n),
    .sclk    (sclk),
    .dout    (dout),
    .dout_oe (dout_oe),
    .pwr_dn  (pwr_dn)
);

// File: tb/sar_adc_serial_bench.sv
module sar_adc_serial_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 12;
    localparam int NVEC       = 8;

    typedef struct packed {
        logic [W-1:0] ain;
        logic [W-1:0] ain_late;
        logic [W-1:0] expect_w;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{12'h000, 12'hFFF, 12'h000},
        '{12'hFFF, 12'h000, 12'hFFF},
        '{12'h800, 12'h7FF, 12'h800},
        '{12'h7FF, 12'h800, 12'h7FF},
        '{12'hA5C, 12'h123, 12'hA5C},
        '{12'h001, 12'hFFE, 12'h001},
        '{12'h555, 12'hAAA, 12'h555},
        '{12'h3C9, 12'h3C9, 12'h3C9}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cs_n = 1'b1;
    logic         sclk = 1'b0;
    logic [W-1:0] ain = '0;
    logic         dout;
    logic         dout_oe;
    logic         pwr_dn;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    sar_adc_serial u_sar_adc_serial (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .sclk    (sclk),
        .ain     (ain),
        .dout    (dout),
        .dout_oe (dout_oe),
        .pwr_dn  (pwr_dn)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_dout(int k, logic [W-1:0] w);
        if (k <= 3) return 1'b0;
        if (k <= 15) return w[15 - k];
        if (k <= 26) return w[k - 15];
        return 1'b0;
    endfunction

    // One serial clock period; the outputs are checked for stability while sclk is high (R10).
    task automatic sclk_fall();
        logic prev_d;
        logic prev_oe;
        prev_d  = dout;
        prev_oe = dout_oe;
        @(negedge clk) sclk = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 dout on rising sclk", {11'b0, dout}, {11'b0, prev_d});
        chk("R10 oe on rising sclk", {11'b0, dout_oe}, {11'b0, prev_oe});
        sclk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic cs_fall();
        @(negedge clk) cs_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R2 pwr_dn after cs fall", {11'b0, pwr_dn}, 12'h000);
        chk("R2 oe after cs fall", {11'b0, dout_oe}, 12'h000);
    endtask

    task automatic cs_rise(input string tag);
        @(negedge clk) cs_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({tag, " oe idle"}, {11'b0, dout_oe}, 12'h000);
        chk({tag, " pwr_dn idle"}, {11'b0, pwr_dn}, 12'h001);
    endtask

    task automatic run_edges(input logic [W-1:0] w, input logic [W-1:0] late, input int n_edges);
        string tag;
        for (int k = 1; k <= n_edges; k++) begin
            sclk_fall();
            if (k == 3) ain = late;
            if (k <= 2) tag = "R2";
            else if (k == 3) tag = "R3";
            else if (k <= 15) tag = "R4/R5";
            else if (k <= 26) tag = "R6";
            else tag = "R7";
            chk($sformatf("%s oe edge %0d", tag, k), {11'b0, dout_oe}, {11'b0, (k >= 3)});
            if (k >= 3)
                chk($sformatf("%s dout edge %0d", tag, k), {11'b0, dout}, {11'b0, exp_dout(k, w)});
            chk($sformatf("R8 pwr_dn edge %0d", k), {11'b0, pwr_dn}, {11'b0, (k >= 16)});
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk("R1 oe in reset", {11'b0, dout_oe}, 12'h000);
        chk("R1 pwr_dn in reset", {11'b0, pwr_dn}, 12'h001);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 oe after reset", {11'b0, dout_oe}, 12'h000);
        chk("R1 pwr_dn after reset", {11'b0, pwr_dn}, 12'h001);

        for (int v = 0; v < NVEC; v++) begin
            ain = VECS[v].ain;
            cs_fall();
            run_edges(VECS[v].expect_w, VECS[v].ain_late, 30);
            cs_rise("R9");
        end

        // R9: abort in the middle of the conversion, then a fresh cycle
        ain = 12'hC3A;
        cs_fall();
        run_edges(12'hC3A, 12'hC3A, 8);
        cs_rise("R9 abort mid conversion");
        ain = 12'h2B7;
        cs_fall();
        run_edges(12'h2B7, 12'h2B7, 30);
        cs_rise("R9");

        // R9: abort inside the sampling window
        ain = 12'h9E1;
        cs_fall();
        run_edges(12'h9E1, 12'h9E1, 1);
        cs_rise("R9 abort in sampling");
        ain = 12'h6D4;
        cs_fall();
        run_edges(12'h6D4, 12'h6D4, 20);
        cs_rise("R9 abort in lsb phase");

        // R7: long run of zeros after the second word
        ain = 12'hFFF;
        cs_fall();
        run_edges(12'hFFF, 12'hFFF, 60);
        cs_rise("R9");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule